// File: doc/BRIEF.md
# XNOR Pseudo-Random Sequence Generator with Full-Cycle Option

This block is a synchronous pseudo-random word source. A Fibonacci shift register takes its new input bit from the inverted parity of a few tap bits. There is no adder or carry chain, so each flop is fed by its neighbour or by one small parity tree. This keeps the path between clock edges short, and a wide instance can deliver a fresh word on every enabled clock edge. A typical use is feeding data patterns to a memory test engine.

Because the feedback is an inverted parity, the all-zero word is an ordinary member of the sequence, and reset can safely load it. The all-ones word is the single state the plain register can never leave, so the normal run skips it and has 2^W − 1 states. With the full-cycle option selected, a detector recognises the state just before all-ones and the all-ones state itself. In both states it inverts the feedback bit, which splices the all-ones word into the loop, so the sequence then passes through all 2^W codes.

Top module: `xnor_seq_gen`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the state becomes all zeros at that edge, whatever `en` is.
- R2: With `rst_n` high and `en` low, the state does not change.
- R3: With `en` high and the full-cycle option off, each edge loads `{s[W-2:0], f}`. Here f is the inverse of the XOR of the tap bits. The taps come from a maximal-length polynomial. For W=8 they are bit indices 7,5,4,3, and for W=32 they are bit indices 31,21,1,0.
- R4: With the full-cycle option off, a state other than all-ones never steps to all-ones.
- R5: With the full-cycle option off, starting from all zeros, the state returns to all zeros after exactly 2^W − 1 steps, and no state repeats before that.
- R6: With the full-cycle option on, the state with bit W-1 clear and all other bits set steps to all-ones.
- R7: With the full-cycle option on, all-ones steps to all-ones with bit 0 cleared.
- R8: With the full-cycle option on, starting from all zeros, the state returns to all zeros after exactly 2^W steps and visits every W-bit code once.
- R9: With the full-cycle option on, every state other than the two in R6 and R7 steps exactly as in R3.
- R10: With the default W=32 and `en` held high, the output presents a new word on every clock edge, and that word follows R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Advance the sequence by one step per edge when high |
| ext_mode | input | 1 | High selects the full 2^W cycle that includes all-ones |
| state_o | output | WIDTH | Current register contents |

## Verification
The assertions assume that `ext_mode` is never cleared while the register holds all-ones. If it were, the plain register would stay in that state forever, and the no-lockup property would not apply. The stimulus changes `ext_mode` only while the state is all zeros, right after a full period. The full 8-bit periods are run with `en` held high, so the step-by-step comparison and the visit map line up with the clock edges. The wide instance starts from reset and never leaves the plain mode.

// File: rtl/xnl_pkg.sv
// Package: shared constants and the maximal-length tap table.
// Assumes: widths from MIN_WIDTH to MAX_WIDTH; other widths give an empty mask.
package xnl_pkg;
    localparam int unsigned MAX_WIDTH = 32;
    localparam int unsigned MIN_WIDTH = 3;

    // One-hot mask for 1-based tap position n
    function automatic logic [MAX_WIDTH-1:0] tap_bit(input int unsigned n);
        logic [MAX_WIDTH-1:0] one;
        one = {{(MAX_WIDTH-1){1'b0}}, 1'b1};
        return one << (n - 1);
    endfunction

    // Tap mask of a maximal-length polynomial (even tap count) for width w
    function automatic logic [MAX_WIDTH-1:0] tap_mask(input int unsigned w);
        logic [MAX_WIDTH-1:0] m;
        case (w)
            3:  m = tap_bit(3)  | tap_bit(2);
            4:  m = tap_bit(4)  | tap_bit(3);
            5:  m = tap_bit(5)  | tap_bit(3);
            6:  m = tap_bit(6)  | tap_bit(5);
            7:  m = tap_bit(7)  | tap_bit(6);
            8:  m = tap_bit(8)  | tap_bit(6)  | tap_bit(5) | tap_bit(4);
            9:  m = tap_bit(9)  | tap_bit(5);
            10: m = tap_bit(10) | tap_bit(7);
            11: m = tap_bit(11) | tap_bit(9);
            12: m = tap_bit(12) | tap_bit(6)  | tap_bit(4) | tap_bit(1);
            13: m = tap_bit(13) | tap_bit(4)  | tap_bit(3) | tap_bit(1);
            14: m = tap_bit(14) | tap_bit(5)  | tap_bit(3) | tap_bit(1);
            15: m = tap_bit(15) | tap_bit(14);
            16: m = tap_bit(16) | tap_bit(15) | tap_bit(13) | tap_bit(4);
            17: m = tap_bit(17) | tap_bit(14);
            18: m = tap_bit(18) | tap_bit(11);
            19: m = tap_bit(19) | tap_bit(6)  | tap_bit(2) | tap_bit(1);
            20: m = tap_bit(20) | tap_bit(17);
            21: m = tap_bit(21) | tap_bit(19);
            22: m = tap_bit(22) | tap_bit(21);
            23: m = tap_bit(23) | tap_bit(18);
            24: m = tap_bit(24) | tap_bit(23) | tap_bit(22) | tap_bit(17);
            25: m = tap_bit(25) | tap_bit(22);
            26: m = tap_bit(26) | tap_bit(6)  | tap_bit(2) | tap_bit(1);
            27: m = tap_bit(27) | tap_bit(5)  | tap_bit(2) | tap_bit(1);
            28: m = tap_bit(28) | tap_bit(25);
            29: m = tap_bit(29) | tap_bit(27);
            30: m = tap_bit(30) | tap_bit(6)  | tap_bit(4) | tap_bit(1);
            31: m = tap_bit(31) | tap_bit(28);
            32: m = tap_bit(32) | tap_bit(22) | tap_bit(2) | tap_bit(1);
            default: m = '0;
        endcase
        return m;
    endfunction
endpackage

// File: rtl/xnl_feedback.sv
// Feedback bit: the inverted parity of the tapped state bits.
// Assumes: WIDTH is in the supported range of xnl_pkg, so the tap count is even.
// With an even tap count, all-ones maps to a 1, which is the lockup point.
module xnl_feedback #(
    parameter int unsigned WIDTH = 32
) (
    input  logic [WIDTH-1:0] q,
    output logic             fb
);
    localparam logic [xnl_pkg::MAX_WIDTH-1:0] FULL_MASK = xnl_pkg::tap_mask(WIDTH);
    localparam logic [WIDTH-1:0] MASK = FULL_MASK[WIDTH-1:0];

    logic [WIDTH-1:0] picked;

    // Keep only the tapped bits; the others add nothing to the parity
    for (genvar i = 0; i < WIDTH; i++) begin : g_tap
        assign picked[i] = q[i] & MASK[i];
    end

    // Inverted parity over the selected taps
    assign fb = ~(^picked);
endmodule

// File: rtl/xnl_splice.sv
// Splice detector: raises flip when the full-cycle option is on and the low
// WIDTH-1 bits are all ones. This is true in the state just before all-ones
// and in all-ones itself.
// Assumes: the top inverts the feedback bit whenever flip is high.
module xnl_splice #(
    parameter int unsigned WIDTH = 32
) (
    input  logic [WIDTH-2:0] q_low,
    input  logic             ext_mode,
    output logic             flip
);
    // Both splice states share the low-bit pattern, so one AND tree serves both
    assign flip = ext_mode & (&q_low);
endmodule

// File: rtl/xnl_state_reg.sv
// State register with synchronous active-low clear and load enable.
// Assumes: d is the next state computed by the surrounding logic.
module xnl_state_reg #(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    // Clear on reset, otherwise load when enabled
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (en)
            q <= d;
    end
endmodule

// File: rtl/xnor_seq_gen.sv
// Top: Fibonacci shift register with inverted-parity feedback and an optional
// splice that adds the all-ones word to give a 2^WIDTH cycle.
// Assumes: ext_mode is not cleared while the state is all-ones.
module xnor_seq_gen #(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             ext_mode,
    output logic [WIDTH-1:0] state_o
);
    localparam logic [WIDTH-1:0] ALL_ONES  = '1;
    localparam logic [WIDTH-1:0] PRE_ONES  = {1'b0, {(WIDTH-1){1'b1}}};
    localparam logic [WIDTH-1:0] POST_ONES = {{(WIDTH-1){1'b1}}, 1'b0};

    logic [WIDTH-1:0] state;
    logic [WIDTH-1:0] next_state;
    logic             fb;
    logic             flip;

    xnl_feedback #(.WIDTH(WIDTH)) u_fb (
        .q  (state),
        .fb (fb)
    );

    xnl_splice #(.WIDTH(WIDTH)) u_splice (
        .q_low    (state[WIDTH-2:0]),
        .ext_mode (ext_mode),
        .flip     (flip)
    );

    // Shift toward the MSB, with the possibly inverted feedback entering bit 0
    always_comb begin
        next_state = {state[WIDTH-2:0], fb ^ flip};
    end

    xnl_state_reg #(.WIDTH(WIDTH)) u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en),
        .d     (next_state),
        .q     (state)
    );

    assign state_o = state;

    // R1: reset clears the state
    a_r1_reset_zero: assert property (@(posedge clk)
        !rst_n |=> state_o == '0);

    // R2: no step without enable
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(state_o));

    // R4: plain mode never enters the lockup word
    a_r4_no_lockup: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !ext_mode && state_o != ALL_ONES) |=> state_o != ALL_ONES);

    // R6: splice entry
    a_r6_enter_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (en && ext_mode && state_o == PRE_ONES) |=> state_o == ALL_ONES);

    // R7: splice exit
    a_r7_leave_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (en && ext_mode && state_o == ALL_ONES) |=> state_o == POST_ONES);
endmodule

// File: tb/test_xnor_seq_gen.sv
module test_xnor_seq_gen;
    localparam int CLK_PERIOD = 10;
    localparam int N8 = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en8 = 1'b0, ext8 = 1'b0;
    logic en32 = 1'b0;
    logic [7:0]  st8;
    logic [31:0] st32;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xnor_seq_gen #(.WIDTH(N8)) i_xnor_seq_gen (
        .clk(clk), .rst_n(rst_n), .en(en8), .ext_mode(ext8), .state_o(st8));

    xnor_seq_gen i_xnor_seq_gen_wide (
        .clk(clk), .rst_n(rst_n), .en(en32), .ext_mode(1'b0), .state_o(st32));

    // Expected 8-bit step from R3/R6/R7/R9: taps at bits 7,5,4,3
    function automatic logic [7:0] model8(input logic [7:0] s, input logic ext);
        logic f;
        f = ~(s[7] ^ s[5] ^ s[4] ^ s[3]);
        if (ext && s[6:0] == 7'h7f) f = ~f;
        return {s[6:0], f};
    endfunction

    // Expected 32-bit step from R3: taps at bits 31,21,1,0
    function automatic logic [31:0] model32(input logic [31:0] s);
        return {s[30:0], ~(s[31] ^ s[21] ^ s[1] ^ s[0])};
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Wait for the edge, then sample a quarter period later
    task automatic tick();
        @(posedge clk);
        #(CLK_PERIOD/4);
    endtask

    task automatic run_period(input bit ext, input int len, input string req);
        bit seen[256];
        logic [7:0] exp;
        bit rep;
        for (int i = 0; i < 256; i++) seen[i] = 1'b0;
        seen[st8] = 1'b1;
        rep = 1'b0;
        exp = st8;
        en8 = 1'b1;
        for (int k = 1; k <= len; k++) begin
            logic [7:0] prev;
            prev = exp;
            exp = model8(prev, ext);
            tick();
            if (ext) check(st8 == exp, "R9 step", {24'h0, st8}, {24'h0, exp});
            else     check(st8 == exp, "R3 step", {24'h0, st8}, {24'h0, exp});
            if (!ext) check(st8 != 8'hff, "R4 lockup avoided", {24'h0, st8}, 32'h0);
            if (ext && prev == 8'h7f)
                check(st8 == 8'hff, "R6 enter all-ones", {24'h0, st8}, 32'hff);
            if (ext && prev == 8'hff)
                check(st8 == 8'hfe, "R7 leave all-ones", {24'h0, st8}, 32'hfe);
            if (k < len) begin
                if (seen[st8]) rep = 1'b1;
                seen[st8] = 1'b1;
            end
        end
        en8 = 1'b0;
        begin
            int cnt;
            cnt = 0;
            for (int i = 0; i < 256; i++) if (seen[i]) cnt++;
            check(st8 == 8'h00, {req, " returns to zero"}, {24'h0, st8}, 32'h0);
            check(!rep, {req, " no repeat"}, {31'h0, rep}, 32'h0);
            check(cnt == len, {req, " distinct states"}, cnt, len);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        tick(); tick();
        check(st8 == 8'h00, "R1 reset 8-bit", {24'h0, st8}, 32'h0);
        check(st32 == 32'h0, "R1 reset 32-bit", st32, 32'h0);
        rst_n = 1'b1;

        // R2: hold with enable low
        tick(); tick();
        check(st8 == 8'h00, "R2 hold", {24'h0, st8}, 32'h0);

        // R5: plain full period
        run_period(1'b0, 255, "R5");

        // R2: hold at a nonzero state
        en8 = 1'b1; tick(); tick(); tick(); en8 = 1'b0;
        begin
            logic [7:0] held;
            held = st8;
            tick(); tick(); tick();
            check(st8 == held, "R2 hold nonzero", {24'h0, st8}, {24'h0, held});
        end

        // R1: reset mid-run with enable low
        rst_n = 1'b0; tick(); rst_n = 1'b1;
        check(st8 == 8'h00, "R1 mid-run reset", {24'h0, st8}, 32'h0);

        // R8: full-cycle period, mode changed only at the all-zero state
        ext8 = 1'b1;
        run_period(1'b1, 256, "R8");
        ext8 = 1'b0;

        // R10: wide instance steps every edge
        en32 = 1'b1;
        begin
            logic [31:0] exp;
            exp = st32;
            for (int k = 0; k < 2000; k++) begin
                logic [31:0] prev;
                prev = exp;
                exp = model32(prev);
                tick();
                check(st32 == exp && st32 != prev, "R10 wide step", st32, exp);
            end
        end
        en32 = 1'b0;

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule